// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Port

This block is the slave side of a three-wire serial link: chip enable, clock and data in, plus a data-out line with its own drive enable. While chip enable is low the host clocks in an 8-bit code. The rising edge of chip enable acts on that code. Two codes open a 32-bit write into one of two control words. A third code opens a read of a status snapshot, and the host may clock out as many bits of it as it likes. Any other code is ignored until chip enable falls again. All serial lines are brought into the system clock domain through synchronizers and edge detectors, so the host clock may idle either high or low.

A written word takes effect on the falling edge of chip enable, and only when exactly 32 data clocks were seen. The first control word also sets the two general-purpose I/O pins, the dedicated open-drain output and the oscillator buffer enable. Both whole words are exported for neighbouring logic to decode. The snapshot read out is the two I/O pin inputs followed by a status vector supplied by neighbouring counters.

Controller states: ST_ADDR (collect code; chip enable low), ST_WR_A and ST_WR_B (shift write data), ST_READ (shift status out), ST_SKIP (unknown code, wait). Transitions: ST_ADDR goes to ST_WR_A, ST_WR_B, ST_READ or ST_SKIP on a chip-enable rise, chosen by the code. Every other state returns to ST_ADDR on a chip-enable fall. A write state commits its word on that same fall.

Top module: `ctlport_top`

## Requirements
- R1: After reset both control words are 0. No I/O pin is pulled low, the dedicated output is released, the buffer enable is 0 and the data-out enable is 0.
- R2: The code is made from the last 8 data bits sampled on clock rising edges while chip enable is low. The bits arrive as B0,B1,B2,B3,A0,A1,A2,A3, and the code is {B3,B2,B1,B0,A3,A2,A1,A0}. Code 0x82 writes control word A.
- R3: Code 0x92 writes control word B and leaves word A unchanged, and 0x82 leaves word B unchanged. At most one word changes per frame.
- R4: Write data bits are sampled on clock rising edges while chip enable is high, and the first bit lands in bit 0. The word updates at the chip-enable fall only if exactly 32 bits were received. With 31 or 33 bits both words keep their values.
- R5: Code 0xA2 captures the snapshot {io_in[1:0], stat_in} at the chip-enable rise. The data-out line shows its MSB once chip enable is high and moves to the next bit on each clock rising edge. After the last bit it shows 0, and any number of clocks is accepted.
- R6: The data-out enable is 1 only during a read frame. It stays 0 during the code phase and during write and unknown frames.
- R7: A frame with any code other than 0x82, 0x92 or 0xA2 changes neither word and does not drive data out, even with 32 data bits.
- R8: All frame types work with the clock idling low and with it idling high.
- R9: Word A decode: bits 0 and 1 are the directions of I/O pins 1 and 2 (1 = output), and bits 2 and 3 are their levels. io_pull_low[i] is direction AND NOT level, so level 1 leaves the pin open. Bit 4 = 1 pulls the dedicated output low. Bit 5 enables the oscillator buffer.
- R10: When the 32nd clock rising edge and the chip-enable fall reach the block in the same system clock cycle, the bit is counted and the word is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_ce | input | 1 | Serial chip enable |
| ser_cl | input | 1 | Serial clock, either idle level |
| ser_di | input | 1 | Serial data from host |
| ser_do | output | 1 | Serial data to host |
| ser_do_oe | output | 1 | Drive enable for ser_do |
| io_in | input | 2 | Levels of the two I/O pins |
| stat_in | input | STAT_W | Status vector from neighbouring counters |
| io_pull_low | output | 2 | Pull I/O pin low (else released) |
| o3_pull_low | output | 1 | Pull dedicated output low (else released) |
| xbuf_en | output | 1 | Oscillator buffer enable |
| ctl_a | output | WORD_W | Control word A |
| ctl_b | output | WORD_W | Control word B |

## Verification
The two events that can fall in one system clock cycle are the last write clock rising edge and the chip-enable falling edge. The controller must shift the bit and judge the length in that same cycle. The bench provokes this by changing ser_cl and ser_ce at one instant, so both pass through identical synchronizers and reach the controller together, in both clock polarities. The result is judged by whether the new word appears at ctl_a or ctl_b and on the pin outputs, compared with a bench model that counts the bit.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;

    localparam logic [7:0] CODE_WR_A = 8'h82;
    localparam logic [7:0] CODE_WR_B = 8'h92;
    localparam logic [7:0] CODE_RD   = 8'hA2;

    localparam int F_DIR1 = 0;
    localparam int F_DIR2 = 1;
    localparam int F_LVL1 = 2;
    localparam int F_LVL2 = 3;
    localparam int F_O3   = 4;
    localparam int F_XBUF = 5;
    localparam int FLD_W  = F_XBUF + 1;

    typedef enum logic [2:0] {
        ST_ADDR,
        ST_WR_A,
        ST_WR_B,
        ST_READ,
        ST_SKIP
    } cp_state_t;

    // raw holds the bits in arrival order, first bit in raw[7]
    function automatic logic [7:0] code_of(input logic [7:0] raw);
        return {raw[4], raw[5], raw[6], raw[7], raw[0], raw[1], raw[2], raw[3]};
    endfunction

endpackage

// File: rtl/ctlport_sync.sv
module ctlport_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din_ctl,
    input  logic         din_dat,
    output logic [N-1:0] lvl_ctl,
    output logic [N-1:0] chg_ctl,
    output logic         lvl_dat
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        logic              prev;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], din_ctl[g]};
                prev  <= chain[STAGES-1];
            end
        end
        assign lvl_ctl[g] = chain[STAGES-1];
        assign chg_ctl[g] = chain[STAGES-1] ^ prev;
    end

    logic [STAGES-1:0] dchain;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dchain <= '0;
        else        dchain <= {dchain[STAGES-2:0], din_dat};
    end
    assign lvl_dat = dchain[STAGES-1];

endmodule

// File: rtl/ctlport_shift.sv
module ctlport_shift #(
    parameter  int W  = 32,
    localparam int CW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          din,
    output logic [W-1:0]  word_nxt,
    output logic [CW-1:0] cnt_nxt
);

    logic [W-1:0]  word;
    logic [CW-1:0] cnt;

    always_comb begin
        word_nxt = word;
        cnt_nxt  = cnt;
        if (clr) begin
            word_nxt = '0;
            cnt_nxt  = '0;
        end else if (en) begin
            word_nxt = {din, word[W-1:1]};
            if (cnt != CW'(W + 1)) cnt_nxt = cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else begin
            word <= word_nxt;
            cnt  <= cnt_nxt;
        end
    end

endmodule

// File: rtl/ctlport_pins.sv
module ctlport_pins
    import ctlport_pkg::*;
(
    input  logic [FLD_W-1:0] fld,
    output logic [1:0]       io_pull_low,
    output logic             o3_pull_low,
    output logic             xbuf_en
);

    always_comb begin
        io_pull_low[0] = fld[F_DIR1] & ~fld[F_LVL1];
        io_pull_low[1] = fld[F_DIR2] & ~fld[F_LVL2];
        o3_pull_low    = fld[F_O3];
        xbuf_en        = fld[F_XBUF];
    end

endmodule

// File: rtl/ctlport_top.sv
module ctlport_top
    import ctlport_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int STAT_W      = 22,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_ce,
    input  logic              ser_cl,
    input  logic              ser_di,
    output logic              ser_do,
    output logic              ser_do_oe,
    input  logic [1:0]        io_in,
    input  logic [STAT_W-1:0] stat_in,
    output logic [1:0]        io_pull_low,
    output logic              o3_pull_low,
    output logic              xbuf_en,
    output logic [WORD_W-1:0] ctl_a,
    output logic [WORD_W-1:0] ctl_b
);

    localparam int RD_W  = STAT_W + 2;
    localparam int CNT_W = $clog2(WORD_W + 2);

    logic ce_lvl, cl_lvl, ce_chg, cl_chg, di_lvl;
    logic ce_rise, ce_fall, cl_rise;

    ctlport_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_ctl ({ser_ce, ser_cl}),
        .din_dat (ser_di),
        .lvl_ctl ({ce_lvl, cl_lvl}),
        .chg_ctl ({ce_chg, cl_chg}),
        .lvl_dat (di_lvl)
    );

    assign ce_rise = ce_chg & ce_lvl;
    assign ce_fall = ce_chg & ~ce_lvl;
    assign cl_rise = cl_chg & cl_lvl;

    cp_state_t         state, state_nxt;
    logic [7:0]        addr_raw, addr_nxt;
    logic [RD_W-1:0]   rd_sr;
    logic [WORD_W-1:0] word_nxt;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              in_write, shift_en;
    logic              commit_a, commit_b, load_rd;

    assign in_write = (state == ST_WR_A) || (state == ST_WR_B);
    assign shift_en = cl_rise & in_write;
    assign addr_nxt = (state == ST_ADDR && cl_rise) ? {addr_raw[6:0], di_lvl} : addr_raw;

    ctlport_shift #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ce_rise),
        .en       (shift_en),
        .din      (di_lvl),
        .word_nxt (word_nxt),
        .cnt_nxt  (cnt_nxt)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ADDR: begin
                if (ce_rise) begin
                    unique case (code_of(addr_nxt))
                        CODE_WR_A: state_nxt = ST_WR_A;
                        CODE_WR_B: state_nxt = ST_WR_B;
                        CODE_RD:   state_nxt = ST_READ;
                        default:   state_nxt = ST_SKIP;
                    endcase
                end
            end
            ST_WR_A, ST_WR_B, ST_READ, ST_SKIP: begin
                if (ce_fall) state_nxt = ST_ADDR;
            end
            default: state_nxt = ST_ADDR;
        endcase
    end

    assign commit_a = (state == ST_WR_A) && ce_fall && (cnt_nxt == CNT_W'(WORD_W));
    assign commit_b = (state == ST_WR_B) && ce_fall && (cnt_nxt == CNT_W'(WORD_W));
    assign load_rd  = (state_nxt == ST_READ) && (state == ST_ADDR);

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_ADDR;
            addr_raw <= '0;
            rd_sr    <= '0;
            ctl_a    <= '0;
            ctl_b    <= '0;
        end else begin
            state    <= state_nxt;
            addr_raw <= ce_fall ? 8'h00 : addr_nxt;
            if (load_rd)
                rd_sr <= {io_in, stat_in};
            else if (state == ST_READ && cl_rise)
                rd_sr <= {rd_sr[RD_W-2:0], 1'b0};
            if (commit_a) ctl_a <= word_nxt;
            if (commit_b) ctl_b <= word_nxt;
        end
    end

    // outputs
    always_comb begin
        ser_do_oe = (state == ST_READ);
        ser_do    = (state == ST_READ) ? rd_sr[RD_W-1] : 1'b0;
    end

    ctlport_pins u_pins (
        .fld         (ctl_a[FLD_W-1:0]),
        .io_pull_low (io_pull_low),
        .o3_pull_low (o3_pull_low),
        .xbuf_en     (xbuf_en)
    );

endmodule

// File: rtl/ctlport_chk.sv
module ctlport_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ce_lvl,
    input logic         ce_rise,
    input logic         ce_fall,
    input logic         ser_do_oe,
    input logic [W-1:0] ctl_a,
    input logic [W-1:0] ctl_b,
    input logic         commit_a,
    input logic         commit_b,
    input logic         load_rd
);

    a_r6_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        ser_do_oe |-> (ce_lvl || $past(ce_lvl)));

    a_r5_oe_starts_at_ce_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_do_oe) |-> $past(ce_rise));

    a_r4_word_a_at_ce_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_a) |-> $past(ce_fall));

    a_r3_word_b_at_ce_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_b) |-> $past(ce_fall));

    a_r3_one_word_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(ctl_a) && !$stable(ctl_b)));

    a_r2_single_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_a, commit_b, load_rd}));

endmodule

bind ctlport_top ctlport_chk #(.W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_lvl    (ce_lvl),
    .ce_rise   (ce_rise),
    .ce_fall   (ce_fall),
    .ser_do_oe (ser_do_oe),
    .ctl_a     (ctl_a),
    .ctl_b     (ctl_b),
    .commit_a  (commit_a),
    .commit_b  (commit_b),
    .load_rd   (load_rd)
);

// File: tb/tb_ctlport_top.sv
module tb_ctlport_top;

    localparam int W  = 32;
    localparam int SW = 22;
    localparam int RW = SW + 2;
    localparam int H  = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, ser_ce, ser_cl, ser_di, ser_do, ser_do_oe;
    logic [1:0]    io_in, io_pull_low;
    logic [SW-1:0] stat_in;
    logic          o3_pull_low, xbuf_en;
    logic [W-1:0]  ctl_a, ctl_b;

    ctlport_top #(.WORD_W(W), .STAT_W(SW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_cl(ser_cl), .ser_di(ser_di),
        .ser_do(ser_do), .ser_do_oe(ser_do_oe), .io_in(io_in), .stat_in(stat_in),
        .io_pull_low(io_pull_low), .o3_pull_low(o3_pull_low), .xbuf_en(xbuf_en),
        .ctl_a(ctl_a), .ctl_b(ctl_b)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [W-1:0] exp_a = '0;
    logic [W-1:0] exp_b = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit addr_bit(input logic [7:0] code, input int k);
        return (k < 4) ? code[4 + k] : code[k - 4];
    endfunction

    function automatic logic [3:0] exp_pins(input logic [W-1:0] a);
        return {a[5], a[4], a[1] & ~a[3], a[0] & ~a[2]};
    endfunction

    task automatic pulse_bit(input bit idle_hi, input bit d);
        if (!idle_hi) begin
            ser_di = d; wait_n(H); ser_cl = 1'b1; wait_n(H); ser_cl = 1'b0;
        end else begin
            ser_cl = 1'b0; ser_di = d; wait_n(H); ser_cl = 1'b1; wait_n(H);
        end
    endtask

    task automatic send_addr(input logic [7:0] code, input bit idle_hi, input string req);
        ser_ce = 1'b0;
        ser_cl = idle_hi;
        wait_n(H);
        for (int k = 0; k < 8; k++) pulse_bit(idle_hi, addr_bit(code, k));
        wait_n(H);
        chk(ser_do_oe == 1'b0, "R6", {req, " oe in code phase"}, ser_do_oe, 0);
        ser_ce = 1'b1;
        wait_n(H);
    endtask

    task automatic check_state(input string req);
        chk(ctl_a == exp_a, req, "ctl_a", ctl_a, exp_a);
        chk(ctl_b == exp_b, req, "ctl_b", ctl_b, exp_b);
        chk({xbuf_en, o3_pull_low, io_pull_low} == exp_pins(exp_a), "R9", "pins",
            {xbuf_en, o3_pull_low, io_pull_low}, exp_pins(exp_a));
        chk(ser_do_oe == 1'b0, "R6", "oe after frame", ser_do_oe, 0);
    endtask

    task automatic write_frame(input logic [7:0] code, input logic [W-1:0] data,
                               input int nbits, input bit idle_hi, input bit tie,
                               input string req);
        send_addr(code, idle_hi, req);
        for (int i = 0; i < nbits; i++) begin
            bit d;
            d = data[i % W];
            if (tie && i == nbits - 1) begin
                if (!idle_hi) begin
                    ser_di = d; wait_n(H); ser_cl = 1'b1; ser_ce = 1'b0; wait_n(H); ser_cl = 1'b0;
                end else begin
                    ser_cl = 1'b0; ser_di = d; wait_n(H); ser_cl = 1'b1; ser_ce = 1'b0; wait_n(H);
                end
            end else begin
                pulse_bit(idle_hi, d);
            end
        end
        if (!tie) begin
            wait_n(H);
            chk(ser_do_oe == 1'b0, "R6", {req, " oe in write"}, ser_do_oe, 0);
            ser_ce = 1'b0;
        end
        wait_n(H);
        if (nbits == W && code == 8'h82) exp_a = data;
        if (nbits == W && code == 8'h92) exp_b = data;
        check_state(req);
    endtask

    task automatic read_frame(input int nclk, input bit idle_hi, input string req);
        logic [RW-1:0] snap;
        io_in   = 2'($urandom);
        stat_in = SW'($urandom);
        snap    = {io_in, stat_in};
        send_addr(8'hA2, idle_hi, req);
        io_in   = ~io_in;
        stat_in = ~stat_in;
        chk(ser_do_oe == 1'b1, "R5", {req, " oe"}, ser_do_oe, 1);
        chk(ser_do == snap[RW-1], "R5", {req, " first bit"}, ser_do, snap[RW-1]);
        for (int k = 1; k <= nclk; k++) begin
            bit e;
            e = (k < RW) ? snap[RW-1-k] : 1'b0;
            if (!idle_hi) begin
                ser_cl = 1'b1; wait_n(H);
                chk(ser_do == e, "R5", {req, " bit"}, ser_do, e);
                ser_cl = 1'b0; wait_n(H);
            end else begin
                ser_cl = 1'b0; wait_n(H); ser_cl = 1'b1; wait_n(H);
                chk(ser_do == e, "R5", {req, " bit"}, ser_do, e);
            end
        end
        ser_ce = 1'b0;
        wait_n(H);
        check_state(req);
    endtask

    initial begin
        #(200000 * 8);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0; ser_ce = 1'b0; ser_cl = 1'b0; ser_di = 1'b0;
        io_in = 2'b00; stat_in = '0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);
        // R1 reset state
        check_state("R1");

        // R2 / R9 word A write, clock idle low, then idle high (R8)
        write_frame(8'h82, 32'h0000_0031, 32, 1'b0, 1'b0, "R2");
        write_frame(8'h82, 32'hA5C3_0F2E, 32, 1'b1, 1'b0, "R8");
        // R3 word B write, A kept
        write_frame(8'h92, 32'h1234_5678, 32, 1'b0, 1'b0, "R3");
        write_frame(8'h92, 32'hFEDC_BA98, 32, 1'b1, 1'b0, "R3");
        // R4 wrong lengths ignored
        write_frame(8'h82, 32'hFFFF_FFFF, 31, 1'b0, 1'b0, "R4");
        write_frame(8'h92, 32'h0000_0000, 33, 1'b1, 1'b0, "R4");
        // R7 unknown codes ignored even with 32 bits
        write_frame(8'h55, 32'h0000_003F, 32, 1'b0, 1'b0, "R7");
        write_frame(8'h28, 32'h0000_003F, 32, 1'b1, 1'b0, "R7");
        // R10 last clock edge coincides with chip-enable fall
        write_frame(8'h82, 32'h0000_001A, 32, 1'b0, 1'b1, "R10");
        write_frame(8'h92, 32'h8000_0001, 32, 1'b1, 1'b1, "R10");
        // R5 reads: short, full, past the end, both polarities
        read_frame(0, 1'b0, "R5");
        read_frame(5, 1'b1, "R5");
        read_frame(RW + 6, 1'b0, "R5");
        read_frame(RW + 6, 1'b1, "R8");

        for (int it = 0; it < 24; it++) begin
            int op;
            bit pol;
            logic [7:0] code;
            op  = int'($urandom % 5);
            pol = 1'($urandom);
            unique case (op)
                0: write_frame(8'h82, $urandom, 32, pol, 1'($urandom), "R2");
                1: write_frame(8'h92, $urandom, 32, pol, 1'($urandom), "R3");
                2: write_frame(($urandom % 2) ? 8'h82 : 8'h92, $urandom,
                               ($urandom % 2) ? 31 : 33, pol, 1'b0, "R4");
                3: begin
                    code = 8'($urandom);
                    while (code == 8'h82 || code == 8'h92 || code == 8'hA2) code = 8'($urandom);
                    write_frame(code, $urandom, 32, pol, 1'b0, "R7");
                end
                default: read_frame(int'($urandom % 30), pol, "R5");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule